// File: doc/BRIEF.md
# I2C Master Transmit/Receive Byte FIFO Pair

This block holds the two byte queues that sit between the register side of an I2C master controller and its bit-level engine. Software pushes bytes into the transmit queue and the engine takes them from its head. In the other direction, the engine pushes the bytes it receives and software pops them. Each queue shows its head byte on a read-data port all the time. That byte reads as zero while the queue is empty.

A single control word sets two 8-bit fill thresholds. Bit 16 of the same word is a one-shot flush that empties both queues. Bit 16 is not stored. A packed word-count output gives both fill levels. Three level flags feed the controller's interrupt status logic:

- transmit empty
- transmit full
- receive level at or above the high threshold

Software reprograms the high threshold for each message. The receive flag therefore follows the threshold value currently stored, from the cycle after it is written.

Top module: `i2c_mst_fifo_pair`

## Requirements
- R1: After reset both levels are 0, `tx_empty` is 1, `tx_full` is 0, `rx_hi` is 0, and `ctl_rdata` reads 0x0000FF00 (high threshold 255, low threshold 0).
- R2: Each queue returns bytes in the order they were accepted, and it shows the oldest byte on its read-data port while it is not empty.
- R3: A push to a queue that holds DEPTH (128) bytes is dropped. The level stays at DEPTH and the head byte does not change.
- R4: While a queue is empty, its read-data port reads 0. A pop is ignored and the level stays 0.
- R5: A push and a pop in the same cycle leave the level unchanged when 0 < level < DEPTH. On an empty queue only the push takes effect (level becomes 1). On a full queue only the pop takes effect (level becomes DEPTH-1).
- R6: A control write stores the high threshold from `ctl_wdata[15:8]` and the low threshold from `ctl_wdata[7:0]`. `ctl_rdata` returns {16'b0, high, low}, and bit 16 always reads 0.
- R7: A control write with `ctl_wdata[16]`=1 empties both queues by the next cycle. In that cycle it takes precedence over every push and pop, and it still updates the thresholds.
- R8: `wcnt_word[7:0]` is the receive level and `wcnt_word[15:8]` is the transmit level. Bits 31:16 are 0.
- R9: `tx_empty` is 1 exactly when the transmit level is 0. `tx_full` is 1 exactly when the transmit level is DEPTH.
- R10: `rx_hi` is 1 exactly when the receive level is greater than or equal to the stored high threshold. A newly written threshold applies from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tx_push | input | 1 | Software pushes `sw_tx_data` into the transmit queue |
| sw_tx_data | input | 8 | Transmit byte from software |
| eng_tx_pop | input | 1 | Engine consumes the transmit head |
| eng_tx_data | output | 8 | Transmit head byte, 0 when empty |
| eng_rx_push | input | 1 | Engine pushes `eng_rx_data` into the receive queue |
| eng_rx_data | input | 8 | Received byte from the engine |
| sw_rx_pop | input | 1 | Software consumes the receive head |
| sw_rx_data | output | 8 | Receive head byte, 0 when empty |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 17 | Control word: [16] flush, [15:8] high threshold, [7:0] low threshold |
| ctl_rdata | output | 32 | Control word readback |
| wcnt_word | output | 32 | Packed fill levels |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_hi | output | 1 | Receive level at or above the high threshold |

## Verification
A wrong pointer or level register shows at the ports in the very next cycle. The head byte on a read-data port goes out of order, or `wcnt_word` disagrees with a count of accepted pushes minus accepted pops. A corrupted level also flips `tx_empty`, `tx_full` or `rx_hi` at once, because all three flags are decoded from the level registers without any further register stage. Wrong pointer wrap at the 128-byte boundary appears only after a full queue has drained, so the full-then-drain sequence and the long random run are what expose it.

// File: rtl/i2c_mst_fifo_pair.sv
module i2c_mst_fifo_pair #(
  parameter int DEPTH  = 128,
  parameter int DW     = 8,
  parameter int TW     = 8,
  parameter int HI_RST = 255,
  parameter int LO_RST = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_tx_push,
  input  logic [DW-1:0] sw_tx_data,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          sw_rx_pop,
  output logic [DW-1:0] sw_rx_data,
  input  logic          ctl_wr,
  input  logic [16:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  output logic [31:0]   wcnt_word,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          rx_hi
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [TW-1:0] hi_thr, lo_thr;
  logic          flush;
  logic [1:0]    push, pop;
  logic [1:0][DW-1:0] wdat, head;
  logic [1:0][LW-1:0] lvl;

  assign flush   = ctl_wr & ctl_wdata[16];
  assign push    = {eng_rx_push, sw_tx_push};
  assign pop     = {sw_rx_pop, eng_tx_pop};
  assign wdat[0] = sw_tx_data;
  assign wdat[1] = eng_rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_thr <= TW'(HI_RST);
      lo_thr <= TW'(LO_RST);
    end else if (ctl_wr) begin
      hi_thr <= ctl_wdata[15:8];
      lo_thr <= ctl_wdata[7:0];
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          take, give;

    assign take = push[c] && (cnt != LW'(DEPTH));
    assign give = pop[c] && (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else if (flush) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (take) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (give) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        case ({take, give})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (take && !flush) mem[wp] <= wdat[c];
    end

    assign head[c] = (cnt == '0) ? '0 : mem[rp];
    assign lvl[c]  = cnt;
  end

  assign eng_tx_data = head[0];
  assign sw_rx_data  = head[1];
  assign tx_empty    = (lvl[0] == '0);
  assign tx_full     = (lvl[0] == LW'(DEPTH));
  assign rx_hi       = (int'(lvl[1]) >= int'(hi_thr));
  assign ctl_rdata   = (32'(hi_thr) << 8) | 32'(lo_thr);
  assign wcnt_word   = (32'(lvl[0]) << 8) | 32'(lvl[1]);

endmodule

// File: rtl/i2c_mst_fifo_pair_chk.sv
module i2c_mst_fifo_pair_chk #(
  parameter int DEPTH = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_tx_push,
  input logic        eng_tx_pop,
  input logic        ctl_wr,
  input logic [16:0] ctl_wdata,
  input logic [7:0]  eng_tx_data,
  input logic [7:0]  sw_rx_data,
  input logic [15:0] wcnt_lo,
  input logic        tx_empty,
  input logic        tx_full,
  input logic        rx_hi
);
  logic flush;
  assign flush = ctl_wr & ctl_wdata[16];

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wcnt_lo == 16'h0) && tx_empty);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && sw_tx_push && !eng_tx_pop && !flush |=> tx_full && $stable(wcnt_lo[15:8]));

  p_tx_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> eng_tx_data == 8'h0);

  p_rx_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt_lo[7:0] == 8'h0) |-> sw_rx_data == 8'h0);

  p_full_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> int'(wcnt_lo[15:8]) == DEPTH);

  p_balanced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && sw_tx_push && eng_tx_pop && !tx_empty && !tx_full |=> $stable(wcnt_lo[15:8]));

  p_thr_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_wdata[16] |=> rx_hi == (wcnt_lo[7:0] >= $past(ctl_wdata[15:8])));
endmodule

bind i2c_mst_fifo_pair i2c_mst_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_tx_push  (sw_tx_push),
  .eng_tx_pop  (eng_tx_pop),
  .ctl_wr      (ctl_wr),
  .ctl_wdata   (ctl_wdata),
  .eng_tx_data (eng_tx_data),
  .sw_rx_data  (sw_rx_data),
  .wcnt_lo     (wcnt_word[15:0]),
  .tx_empty    (tx_empty),
  .tx_full     (tx_full),
  .rx_hi       (rx_hi)
);

// File: tb/i2c_mst_fifo_pair_tb.sv
module i2c_mst_fifo_pair_tb;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_tx_push = 0, eng_tx_pop = 0, eng_rx_push = 0, sw_rx_pop = 0, ctl_wr = 0;
  logic [7:0] sw_tx_data = 0, eng_rx_data = 0;
  logic [16:0] ctl_wdata = 0;
  logic [7:0] eng_tx_data, sw_rx_data;
  logic [31:0] ctl_rdata, wcnt_word;
  logic tx_empty, tx_full, rx_hi;

  always #2 clk = ~clk;

  i2c_mst_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .sw_tx_push(sw_tx_push), .sw_tx_data(sw_tx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .sw_rx_pop(sw_rx_pop), .sw_rx_data(sw_rx_data),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .wcnt_word(wcnt_word), .tx_empty(tx_empty), .tx_full(tx_full), .rx_hi(rx_hi)
  );

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] hi_m = 8'd255, lo_m = 8'd0;
  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] headof(input logic [7:0] q[$]);
    return (q.size() == 0) ? 8'h00 : q[0];
  endfunction

  task automatic check_all();
    chk("R8 wcnt_word", wcnt_word, (32'(txq.size()) << 8) | 32'(rxq.size()));
    chk("R9 tx_empty", 32'(tx_empty), 32'(txq.size() == 0));
    chk("R9 tx_full", 32'(tx_full), 32'(txq.size() == DEPTH));
    chk("R10 rx_hi", 32'(rx_hi), 32'(rxq.size() >= int'(hi_m)));
    chk(txq.size() == 0 ? "R4 tx head" : "R2 tx head", 32'(eng_tx_data), 32'(headof(txq)));
    chk(rxq.size() == 0 ? "R4 rx head" : "R2 rx head", 32'(sw_rx_data), 32'(headof(rxq)));
    chk("R6 ctl_rdata", ctl_rdata, {16'h0, hi_m, lo_m});
  endtask

  task automatic model_step();
    if (ctl_wr) begin
      hi_m = ctl_wdata[15:8];
      lo_m = ctl_wdata[7:0];
    end
    if (ctl_wr && ctl_wdata[16]) begin
      txq.delete();
      rxq.delete();
    end else begin
      bit tp, tg, rp, rg;
      tg = eng_tx_pop && txq.size() > 0;
      tp = sw_tx_push && txq.size() < DEPTH;
      rg = sw_rx_pop && rxq.size() > 0;
      rp = eng_rx_push && rxq.size() < DEPTH;
      if (tg) void'(txq.pop_front());
      if (tp) txq.push_back(sw_tx_data);
      if (rg) void'(rxq.pop_front());
      if (rp) rxq.push_back(eng_rx_data);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    sw_tx_push = 0; eng_tx_pop = 0; eng_rx_push = 0; sw_rx_pop = 0; ctl_wr = 0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] h0;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wcnt", wcnt_word, 32'h0);
    chk("R1 tx_empty", 32'(tx_empty), 32'd1);
    chk("R1 tx_full", 32'(tx_full), 32'd0);
    chk("R1 rx_hi", 32'(rx_hi), 32'd0);
    chk("R1 ctl_rdata", ctl_rdata, 32'h0000FF00);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2/R3: fill transmit queue to DEPTH, then push while full
    for (int i = 0; i < DEPTH; i++) begin
      sw_tx_push = 1; sw_tx_data = 8'(i * 3 + 1);
      step();
    end
    h0 = eng_tx_data;
    sw_tx_push = 1; sw_tx_data = 8'hAA;
    step();
    chk("R3 level at full", wcnt_word[15:8], 32'(DEPTH));
    chk("R3 head kept", 32'(eng_tx_data), 32'(h0));
    // R5: push and pop together on a full queue
    sw_tx_push = 1; eng_tx_pop = 1; sw_tx_data = 8'h5C;
    step();
    chk("R5 full push+pop", wcnt_word[15:8], 32'(DEPTH - 1));
    // R2: drain in order
    for (int i = 0; i < DEPTH; i++) begin
      eng_tx_pop = 1;
      step();
    end
    // R4: pop from empty
    eng_tx_pop = 1;
    step();
    chk("R4 tx pop empty", 32'(eng_tx_data), 32'h0);
    // R5: push and pop together on empty queue
    sw_tx_push = 1; eng_tx_pop = 1; sw_tx_data = 8'h3E;
    step();
    chk("R5 empty push+pop", wcnt_word[15:8], 32'd1);

    // R10: threshold reprogramming on receive queue
    for (int i = 0; i < 5; i++) begin
      eng_rx_push = 1; eng_rx_data = 8'(8'hC0 + i);
      step();
    end
    ctl_wr = 1; ctl_wdata = {1'b0, 8'd3, 8'd1};
    step();
    chk("R10 hi=3 lvl=5", 32'(rx_hi), 32'd1);
    ctl_wr = 1; ctl_wdata = {1'b0, 8'd6, 8'd2};
    step();
    chk("R10 hi=6 lvl=5", 32'(rx_hi), 32'd0);
    ctl_wr = 1; ctl_wdata = {1'b1, 8'd0, 8'h44};
    eng_rx_push = 1; sw_tx_push = 1; sw_rx_pop = 1; eng_tx_pop = 1;
    step();
    chk("R7 flush both", wcnt_word, 32'h0);
    chk("R10 hi=0 on empty", 32'(rx_hi), 32'd1);
    chk("R6 bit16 reads 0", ctl_rdata, 32'h00000044);
    sw_rx_pop = 1;
    step();
    chk("R4 rx pop empty", 32'(sw_rx_data), 32'h0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      int phase;
      phase = (n / 500) % 3;
      sw_tx_push  = ($urandom % 4) < (phase == 0 ? 3 : (phase == 1 ? 1 : 2));
      eng_tx_pop  = ($urandom % 4) < (phase == 1 ? 3 : (phase == 0 ? 1 : 2));
      eng_rx_push = ($urandom % 4) < (phase == 0 ? 3 : (phase == 1 ? 1 : 2));
      sw_rx_pop   = ($urandom % 4) < (phase == 1 ? 3 : (phase == 0 ? 1 : 2));
      sw_tx_data  = 8'($urandom);
      eng_rx_data = 8'($urandom);
      if ($urandom % 40 == 0) begin
        ctl_wr = 1;
        ctl_wdata = {($urandom % 6 == 0) ? 1'b1 : 1'b0, 8'($urandom % 140), 8'($urandom)};
      end
      step();
    end
    finish_run();
  end
endmodule